// File: doc/BRIEF.md
# Sync Point Threshold Interrupt Unit

This block sits beside a bank of sync point counters and turns "counter has reached a target value" into interrupts for two CPUs. Software programs a 16-bit target for each sync point ID, arms the IDs it cares about separately for each CPU, and is then interrupted when an armed counter reaches or passes its target. The counters are inputs to the block. It only compares against them.

Each ID has a target register. Arming is shared control: there is one set-only arm register per CPU, and one disarm register that clears the arm bit for both CPUs. Each CPU also has a sticky status word that is cleared by writing ones. The comparison takes the low 16 bits of the counter minus the target as a signed 16-bit number, so a counter that wraps past zero is still handled correctly. The intended service routine is to disarm the ID and then clear its status bit. If the status bit were cleared first, it would be set again at once while the ID is still armed.

The register port is a single-cycle write strobe with a combinational read of the addressed word. Byte addresses are 10 bits wide. Target registers sit at 4 × ID.

Top module: `sp_thresh_irq`

## Requirements
- R1: After reset, every target is 0, both arm masks and both status words are 0, and both interrupt outputs are low.
- R2: The target for ID n is written and read at byte address 4×n (0x000 to 0x07C). Only bits 15:0 of the write data are stored, and bits 31:16 read as zero.
- R3: ID n meets its target when ((counter_n[15:0] − target_n) mod 2^16) has bit 15 clear. This holds across wraparound: target 0xFFF0 is met by count 0x0005 and target 0x0010 is not met by count 0xFFF0.
- R4: Writing to 0x100 (CPU0) or 0x104 (CPU1) sets the arm bit n of that CPU for every data bit n that is 1. Zero bits leave the arm bits unchanged. Reading the same address returns that CPU's arm mask.
- R5: Writing to 0x108 clears arm bit n for both CPUs for every data bit n that is 1. Zero bits have no effect, and this address reads as zero.
- R6: A status bit is set on the clock edge after its ID is armed for that CPU and meets its target. It stays set after the counter moves away from the target.
- R7: Status words at 0x110 (CPU0) and 0x114 (CPU1) read back their bits. Writing a 1 to bit n clears bit n of that CPU only. If the set condition still holds in the same cycle, the bit stays set.
- R8: The interrupt output of each CPU is high exactly while any bit of that CPU's status word is set.
- R9: Disarming an ID and then clearing its status bit leaves that bit clear and the interrupt low, even while the counter stays at or past its target.
- R10: Reads of any other address, including unaligned addresses inside the target range, return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 10 | Byte address for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word, combinational |
| cnt_vals | input | 1024 | Current counter value of each ID, 32 bits per ID, ID n at bits 32n+31:32n |
| irq_cpu0 | output | 1 | CPU0 threshold interrupt |
| irq_cpu1 | output | 1 | CPU1 threshold interrupt |

## Verification
A wrong arm bit or a wrong stored target shows up at the interrupt pins one edge after the counter meets the target. It can also be read directly from the arm and target registers in the same cycle. A status bit that fails to stick, clears the wrong CPU, or loses to a clear while its set condition still holds shows on the interrupt pin and in the status word on the very next edge. The bench keeps its own model of targets, arm masks and status words. It compares both interrupt pins and the read port against that model every cycle, so a divergence is reported in the cycle it first becomes visible.

// File: rtl/sp_thresh_pkg.sv
package sp_thresh_pkg;

  localparam int unsigned NUM_CPUS = 2;

  // Control word byte offsets; target registers occupy 4*ID below these.
  localparam int unsigned OFS_ARM0   = 32'h100;
  localparam int unsigned OFS_ARM1   = 32'h104;
  localparam int unsigned OFS_DISARM = 32'h108;
  localparam int unsigned OFS_STAT0  = 32'h110;
  localparam int unsigned OFS_STAT1  = 32'h114;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_THR,
    SEL_ARM0,
    SEL_ARM1,
    SEL_DISARM,
    SEL_STAT0,
    SEL_STAT1
  } reg_sel_e;

endpackage

// File: rtl/sp_thr_bank.sv
module sp_thr_bank #(
  parameter int unsigned NUM_IDS = 32,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned THR_W   = 16,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [IDX_W-1:0]           rd_idx,
  input  logic [NUM_IDS*CNT_W-1:0]   cnt_vals,
  output logic [THR_W-1:0]           rd_thr,
  output logic [NUM_IDS-1:0]         met
);

  logic [NUM_IDS-1:0][THR_W-1:0] thr_all;

  for (genvar i = 0; i < NUM_IDS; i++) begin : g_id
    logic             we;
    logic [THR_W-1:0] thr_q;
    logic [THR_W-1:0] thr_d;
    logic [THR_W-1:0] diff;

    always_comb begin
      we    = wr_en && (wr_idx == IDX_W'(i));
      thr_d = wr_data[THR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        thr_q <= '0;
      end else if (we) begin
        thr_q <= thr_d;
      end
    end

    // Signed distance of counter from target; non-negative means reached.
    always_comb begin
      diff   = cnt_vals[i*CNT_W +: THR_W] - thr_q;
      met[i] = ~diff[THR_W-1];
    end

    assign thr_all[i] = thr_q;

    // R2
    thr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(i)) |=> (thr_q == $past(wr_data[THR_W-1:0])));
  end

  assign rd_thr = thr_all[rd_idx];

endmodule

// File: rtl/sp_arm_ctrl.sv
module sp_arm_ctrl #(
  parameter int unsigned NUM_IDS  = 32,
  parameter int unsigned NUM_CPUS = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_CPUS-1:0]                arm_we,
  input  logic                               disarm_we,
  input  logic [NUM_IDS-1:0]                 wmask,
  output logic [NUM_CPUS-1:0][NUM_IDS-1:0]   armed
);

  logic [NUM_CPUS-1:0][NUM_IDS-1:0] armed_q;
  logic [NUM_CPUS-1:0][NUM_IDS-1:0] armed_d;
  logic [NUM_IDS-1:0]               drop_mask;
  logic                             upd_en;

  always_comb begin
    drop_mask = disarm_we ? wmask : '0;
    upd_en    = (|arm_we) || disarm_we;
    for (int c = 0; c < NUM_CPUS; c++) begin
      armed_d[c] = (armed_q[c] | (arm_we[c] ? wmask : '0)) & ~drop_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= '0;
    end else if (upd_en) begin
      armed_q <= armed_d;
    end
  end

  assign armed = armed_q;

  // R4
  arm_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_we[0] && !disarm_we) |=> ((armed_q[0] & $past(wmask)) == $past(wmask)));

  // R5
  disarm_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_we |=> (((armed_q[0] | armed_q[NUM_CPUS-1]) & $past(wmask)) == '0));

  // R4
  zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((|arm_we) || disarm_we) && (wmask == '0)) |=> $stable(armed_q));

endmodule

// File: rtl/sp_status_bank.sv
module sp_status_bank #(
  parameter int unsigned NUM_IDS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_we,
  input  logic [NUM_IDS-1:0] clr_mask,
  input  logic [NUM_IDS-1:0] set_vec,
  output logic [NUM_IDS-1:0] status,
  output logic               irq
);

  logic [NUM_IDS-1:0] status_q;
  logic [NUM_IDS-1:0] status_d;
  logic [NUM_IDS-1:0] clr_eff;
  logic               upd_en;

  always_comb begin
    clr_eff  = clr_we ? clr_mask : '0;
    upd_en   = clr_we || (|set_vec);
    // A persisting set condition wins over a same-cycle clear.
    status_d = (status_q & ~clr_eff) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (upd_en) begin
      status_q <= status_d;
    end
  end

  assign status = status_q;
  assign irq    = |status_q;

  // R6
  status_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(set_vec)) == '0));

  // R6
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_q) & ~$past(clr_eff) & ~status_q) == '0));

  // R7
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((status_q & $past(clr_mask & ~set_vec)) == '0));

endmodule

// File: rtl/sp_thresh_irq.sv
module sp_thresh_irq
  import sp_thresh_pkg::*;
#(
  parameter int unsigned NUM_IDS = 32,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned THR_W   = 16,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  input  logic [NUM_IDS*CNT_W-1:0] cnt_vals,
  output logic                     irq_cpu0,
  output logic                     irq_cpu1
);

  localparam int unsigned IDX_W = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1;
  localparam logic [ADDR_W-1:0] THR_END  = ADDR_W'(NUM_IDS * 4);
  localparam logic [ADDR_W-1:0] A_ARM0   = ADDR_W'(OFS_ARM0);
  localparam logic [ADDR_W-1:0] A_ARM1   = ADDR_W'(OFS_ARM1);
  localparam logic [ADDR_W-1:0] A_DISARM = ADDR_W'(OFS_DISARM);
  localparam logic [ADDR_W-1:0] A_STAT0  = ADDR_W'(OFS_STAT0);
  localparam logic [ADDR_W-1:0] A_STAT1  = ADDR_W'(OFS_STAT1);

  reg_sel_e                          sel;
  logic [IDX_W-1:0]                  idx;
  logic [NUM_IDS-1:0]                wmask;
  logic                              thr_we;
  logic [NUM_CPUS-1:0]               arm_we;
  logic                              disarm_we;
  logic [NUM_CPUS-1:0]               clr_we;
  logic [THR_W-1:0]                  rd_thr;
  logic [NUM_IDS-1:0]                met;
  logic [NUM_CPUS-1:0][NUM_IDS-1:0]  armed;
  logic [NUM_CPUS-1:0][NUM_IDS-1:0]  status;
  logic [NUM_CPUS-1:0]               irq;

  // Address decode
  always_comb begin
    sel = SEL_NONE;
    if ((reg_addr < THR_END) && (reg_addr[1:0] == 2'b00)) begin
      sel = SEL_THR;
    end else begin
      case (reg_addr)
        A_ARM0:   sel = SEL_ARM0;
        A_ARM1:   sel = SEL_ARM1;
        A_DISARM: sel = SEL_DISARM;
        A_STAT0:  sel = SEL_STAT0;
        A_STAT1:  sel = SEL_STAT1;
        default:  sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    idx       = reg_addr[IDX_W+1:2];
    wmask     = reg_wdata[NUM_IDS-1:0];
    thr_we    = reg_wr && (sel == SEL_THR);
    arm_we[0] = reg_wr && (sel == SEL_ARM0);
    arm_we[1] = reg_wr && (sel == SEL_ARM1);
    disarm_we = reg_wr && (sel == SEL_DISARM);
    clr_we[0] = reg_wr && (sel == SEL_STAT0);
    clr_we[1] = reg_wr && (sel == SEL_STAT1);
  end

  sp_thr_bank #(
    .NUM_IDS (NUM_IDS),
    .CNT_W   (CNT_W),
    .THR_W   (THR_W),
    .DATA_W  (DATA_W)
  ) u_thr_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (thr_we),
    .wr_idx   (idx),
    .wr_data  (reg_wdata),
    .rd_idx   (idx),
    .cnt_vals (cnt_vals),
    .rd_thr   (rd_thr),
    .met      (met)
  );

  sp_arm_ctrl #(
    .NUM_IDS  (NUM_IDS),
    .NUM_CPUS (NUM_CPUS)
  ) u_arm_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_we    (arm_we),
    .disarm_we (disarm_we),
    .wmask     (wmask),
    .armed     (armed)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [NUM_IDS-1:0] set_vec;
    assign set_vec = armed[c] & met;

    sp_status_bank #(
      .NUM_IDS (NUM_IDS)
    ) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_we   (clr_we[c]),
      .clr_mask (wmask),
      .set_vec  (set_vec),
      .status   (status[c]),
      .irq      (irq[c])
    );
  end

  // Read mux
  always_comb begin
    case (sel)
      SEL_THR:   reg_rdata = DATA_W'(rd_thr);
      SEL_ARM0:  reg_rdata = DATA_W'(armed[0]);
      SEL_ARM1:  reg_rdata = DATA_W'(armed[1]);
      SEL_STAT0: reg_rdata = DATA_W'(status[0]);
      SEL_STAT1: reg_rdata = DATA_W'(status[1]);
      default:   reg_rdata = '0;
    endcase
  end

  assign irq_cpu0 = irq[0];
  assign irq_cpu1 = irq[1];

  // R10
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel == SEL_NONE) |=> $stable(armed));

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status) == '0 && $past(armed) == '0) |-> !(irq_cpu0 || irq_cpu1));

endmodule

// File: tb/sp_thresh_irq_bench.sv
module sp_thresh_irq_bench;

  localparam int N = 32;

  logic          clk;
  logic          rst_n;
  logic          reg_wr;
  logic [9:0]    reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic [N*32-1:0] cnt_flat;
  logic          irq_cpu0;
  logic          irq_cpu1;

  logic [31:0] cnt_arr [N];

  int n_checks;
  int n_fail;
  bit done;

  // Reference model state
  int          m_thr [N];
  bit [31:0]   m_arm0, m_arm1, m_st0, m_st1;

  sp_thresh_irq u_sp_thresh_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cnt_vals  (cnt_flat),
    .irq_cpu0  (irq_cpu0),
    .irq_cpu1  (irq_cpu1)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 8 ns period, 125 MHz

  always_comb begin
    for (int i = 0; i < N; i++) cnt_flat[i*32 +: 32] = cnt_arr[i];
  end

  function automatic bit reached(int cnt, int thr);
    int d;
    d = ((cnt & 32'hFFFF) - thr) & 32'hFFFF;
    return d < 32'h8000;
  endfunction

  function automatic bit [31:0] model_read(int a);
    if (a < 4 * N && (a % 4) == 0) return 32'(m_thr[a / 4]);
    if (a == 32'h100) return m_arm0;
    if (a == 32'h104) return m_arm1;
    if (a == 32'h110) return m_st0;
    if (a == 32'h114) return m_st1;
    return 32'h0;
  endfunction

  function automatic string area_tag(int a);
    if (a < 4 * N) return "R2";
    if (a == 32'h100 || a == 32'h104) return "R4";
    if (a == 32'h108) return "R5";
    if (a == 32'h110 || a == 32'h114) return "R7";
    return "R10";
  endfunction

  // Model: one step per clock edge, using the state before the edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_thr[i] = 0;
      m_arm0 = '0; m_arm1 = '0; m_st0 = '0; m_st1 = '0;
    end else begin
      bit [31:0] hit;
      bit [31:0] s0, s1;
      int a;
      hit = '0;
      for (int i = 0; i < N; i++) hit[i] = reached(int'(cnt_arr[i]), m_thr[i]);
      s0 = m_st0; s1 = m_st1;
      a = int'(reg_addr);
      if (reg_wr) begin
        if (a < 4 * N && (a % 4) == 0) m_thr[a / 4] = int'(reg_wdata) & 32'hFFFF;
        if (a == 32'h110) s0 = s0 & ~reg_wdata;
        if (a == 32'h114) s1 = s1 & ~reg_wdata;
      end
      s0 = s0 | (m_arm0 & hit);
      s1 = s1 | (m_arm1 & hit);
      m_st0 = s0; m_st1 = s1;
      if (reg_wr) begin
        if (a == 32'h100) m_arm0 = m_arm0 | reg_wdata;
        if (a == 32'h104) m_arm1 = m_arm1 | reg_wdata;
        if (a == 32'h108) begin
          m_arm0 = m_arm0 & ~reg_wdata;
          m_arm1 = m_arm1 & ~reg_wdata;
        end
      end
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      check(irq_cpu0 == (m_st0 != 0), "R8 irq_cpu0", 32'(irq_cpu0), 32'(m_st0 != 0));
      check(irq_cpu1 == (m_st1 != 0), "R8 irq_cpu1", 32'(irq_cpu1), 32'(m_st1 != 0));
      check(reg_rdata == model_read(int'(reg_addr)), area_tag(int'(reg_addr)),
            reg_rdata, model_read(int'(reg_addr)));
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 10'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic expect_rd(int a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = 10'(a);
    #3;
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic expect_irq(bit e0, bit e1, string tag);
    @(negedge clk);
    #3;
    check(irq_cpu0 == e0, tag, 32'(irq_cpu0), 32'(e0));
    check(irq_cpu1 == e1, tag, 32'(irq_cpu1), 32'(e1));
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    for (int i = 0; i < N; i++) cnt_arr[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    expect_irq(1'b0, 1'b0, "R1 irq after reset");
    expect_rd(32'h014, 32'h0, "R1 target reset");
    expect_rd(32'h100, 32'h0, "R1 arm reset");
    expect_rd(32'h110, 32'h0, "R1 status reset");

    // R2: placement and 16-bit truncation
    wr(32'h00C, 32'hABCD_1234);
    expect_rd(32'h00C, 32'h0000_1234, "R2 target id3");
    wr(32'h07C, 32'hFFFF_FFFF);
    expect_rd(32'h07C, 32'h0000_FFFF, "R2 target id31");

    // R3/R6/R8: below target, then reached
    cnt_arr[3] = 32'h0000_1233;
    wr(32'h100, 32'h0000_0008);
    expect_irq(1'b0, 1'b0, "R3 below target");
    expect_irq(1'b0, 1'b0, "R3 below target hold");
    cnt_arr[3] = 32'h0001_1234;
    expect_irq(1'b1, 1'b0, "R6 status set on reach");
    expect_rd(32'h110, 32'h0000_0008, "R6 status0 word");

    // R3: wraparound both ways
    wr(32'h01C, 32'h0000_FFF0);
    cnt_arr[7] = 32'h0000_0005;
    wr(32'h020, 32'h0000_0010);
    cnt_arr[8] = 32'h0000_FFF0;
    wr(32'h104, 32'h0000_0080);
    expect_irq(1'b1, 1'b1, "R3 wrapped count reaches");
    wr(32'h100, 32'h0000_0100);
    expect_irq(1'b1, 1'b1, "R3 settle");
    expect_rd(32'h110, 32'h0000_0008, "R3 wrapped target not met");
    expect_rd(32'h114, 32'h0000_0080, "R7 status1 word");

    // R4/R5: zero writes change nothing
    wr(32'h100, 32'h0);
    wr(32'h108, 32'h0);
    expect_rd(32'h100, 32'h0000_0108, "R4 zero write arm0");
    expect_rd(32'h104, 32'h0000_0080, "R5 zero disarm arm1");
    expect_rd(32'h108, 32'h0, "R5 disarm reads zero");

    // R6: sticky after counter moves back
    cnt_arr[3] = 32'h0;
    expect_irq(1'b1, 1'b1, "R6 sticky");
    expect_rd(32'h110, 32'h0000_0008, "R6 sticky word");

    // R7: clear when no longer met, then re-set, then set wins over clear
    wr(32'h110, 32'h0000_0008);
    expect_rd(32'h110, 32'h0, "R7 cleared");
    check(irq_cpu0 == 1'b0, "R8 low after clear", 32'(irq_cpu0), 32'h0);
    cnt_arr[3] = 32'h0000_1234;
    expect_rd(32'h110, 32'h0000_0008, "R7 re-set");
    wr(32'h110, 32'h0000_0008);
    expect_rd(32'h110, 32'h0000_0008, "R7 set wins");

    // R9: disarm then clear
    wr(32'h108, 32'h0000_0008);
    wr(32'h110, 32'h0000_0008);
    expect_irq(1'b0, 1'b1, "R9 serviced");
    expect_irq(1'b0, 1'b1, "R9 stays clear");
    expect_rd(32'h100, 32'h0000_0100, "R9 arm0 after disarm");

    // R5/R7: disarm reaches both CPUs; clears are per CPU
    wr(32'h100, 32'h0000_0080);
    expect_rd(32'h110, 32'h0000_0080, "R7 cpu0 bit7 set");
    wr(32'h108, 32'h0000_0080);
    expect_rd(32'h100, 32'h0000_0100, "R5 cpu0 disarmed");
    expect_rd(32'h104, 32'h0, "R5 cpu1 disarmed");
    wr(32'h110, 32'h0000_0080);
    expect_rd(32'h114, 32'h0000_0080, "R7 cpu1 untouched");
    expect_irq(1'b0, 1'b1, "R7 cpu independence");
    wr(32'h114, 32'h0000_0080);
    expect_irq(1'b0, 1'b0, "R8 cpu1 low");

    // R10: unmapped and unaligned
    wr(32'h200, 32'hFFFF_FFFF);
    expect_rd(32'h200, 32'h0, "R10 unmapped read");
    expect_rd(32'h100, 32'h0000_0100, "R10 arm0 unchanged");
    wr(32'h006, 32'h0000_5555);
    expect_rd(32'h004, 32'h0, "R10 unaligned write ignored");
    expect_rd(32'h006, 32'h0, "R10 unaligned read");

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule